// File: doc/BRIEF.md
# Serial Port FIFO, Interrupt and Status Unit

This unit sits between a serial receiver, a serial transmitter and the host side of a serial port. Received characters arrive on a strobe together with break, framing and parity error bits. Each one is stored with its flags in a 16-entry receive queue. The host reads characters from the head of that queue. Host writes go into an 8-entry transmit queue, which the transmitter drains one character per pop request. The shifting of bits on the line is handled outside this unit.

The unit keeps three sticky status bits: transmit service due, receive service due and receive timeout. The thresholds that set them are programmable. A combined interrupt request is formed from these bits and two enable inputs. Software clears a status bit by writing it as 0.

On an overrun, the offending character is not lost. It is held aside and later delivered with an overrun mark. Each queue can be flushed individually, but only when a separate enable is asserted in the same control write. A soft reset flushes both queues and clears all status over a fixed number of cycles, and reports itself busy during that time.

Top module: `uart_fifo_status`

## Requirements
- R1: The receive queue holds up to 16 characters in arrival order. `rx_head_data`/`rx_head_flags` show the oldest character without a read. `rx_fill` (5 bits) gives the number stored and changes on the clock edge that accepts a push or a pop.
- R2: `st_rx_due` becomes 1 one edge after `rx_fill` reaches the level chosen by `rx_lvl_sel`. The codes are 0 → 1, 1 → 4, 2 → 8 and 3 → 12 characters.
- R3: `st_tx_due` becomes 1 one edge after the transmit queue is empty, when `tx_lvl_empty`=1. When `tx_lvl_empty`=0, it becomes 1 one edge after the transmit queue is not full.
- R4: A `st_clr` pulse clears each status bit whose `st_clr_keep` bit is 0 (bit 2 transmit due, bit 1 receive due, bit 0 timeout). A keep bit of 1 leaves its status bit unchanged. A condition that still holds sets its bit again on the next edge.
- R5: `irq` = (`st_tx_due` and `ie_tx`) or ((`st_rx_due` or `st_rx_tout`) and `ie_rx`).
- R6: `st_rx_tout` is set when the receive queue is non-empty and `tout_ticks` (non-zero) `bit_tick` pulses have passed with no push or pop.
- R7: A character pushed into a full receive queue is held in a one-entry spill slot and marked with the overrun flag. It enters the queue when a slot frees and is read after all older characters. Further pushes while the spill slot is occupied are discarded.
- R8: `rx_head_flags` bits are [3] break, [2] framing, [1] parity, [0] overrun. When break is set, framing and parity read as 0.
- R9: `rx_none` is 1 exactly when the receive queue holds no character.
- R10: The transmit queue holds up to 8 characters, delivered in write order on `tx_head_data`. A write while it is full is discarded and sets `tx_wr_err`, which stays set until a soft reset.
- R11: A `fctl_wr` pulse flushes the transmit and/or receive queue (`fctl_rst_tx`, `fctl_rst_rx`) only if `fctl_rst_en` is 1 in the same pulse. Otherwise the queues are unchanged.
- R12: A `swrst_req` pulse raises `swrst_busy` on the same edge for `SWRST_CYCLES` (default 4) edges, after which it clears by itself. During that time both queues and the spill slot are emptied, all status bits and `tx_wr_err` are cleared, and pushes and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One pulse per serial bit period, for the timeout |
| rx_push | input | 1 | Receiver delivers a character |
| rx_char | input | 8 | Received character |
| rx_err | input | 3 | Received error bits: [2] break, [1] framing, [0] parity |
| rx_pop | input | 1 | Host reads the head of the receive queue |
| rx_head_data | output | 8 | Character at the receive head |
| rx_head_flags | output | 4 | Flags of the receive head character |
| rx_fill | output | 5 | Receive queue fill count |
| rx_none | output | 1 | No valid receive data |
| tx_wr | input | 1 | Host writes a character |
| tx_wdata | input | 8 | Character to transmit |
| tx_pop | input | 1 | Transmitter takes the head character |
| tx_head_data | output | 8 | Character at the transmit head |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_wr_err | output | 1 | Sticky: write attempted while full |
| rx_lvl_sel | input | 2 | Receive threshold code |
| tx_lvl_empty | input | 1 | 1: transmit due on empty, 0: on not full |
| tout_ticks | input | 8 | Idle bit periods before timeout |
| ie_tx | input | 1 | Transmit interrupt enable |
| ie_rx | input | 1 | Receive interrupt enable |
| st_clr | input | 1 | Status clear strobe |
| st_clr_keep | input | 3 | Per-bit keep mask for the clear |
| fctl_wr | input | 1 | Queue reset control strobe |
| fctl_rst_en | input | 1 | Enable for queue resets |
| fctl_rst_tx | input | 1 | Flush transmit queue |
| fctl_rst_rx | input | 1 | Flush receive queue |
| swrst_req | input | 1 | Soft reset request |
| swrst_busy | output | 1 | Soft reset in progress |
| st_tx_due | output | 1 | Transmit service status |
| st_rx_due | output | 1 | Receive service status |
| st_rx_tout | output | 1 | Receive timeout status |
| irq | output | 1 | Interrupt request |

## Verification
Queue contents, head data, flags and fill counts change on the edge that accepts the push or pop. The three status bits follow one edge later, `irq` moves in the same cycle as the status bits, and `swrst_busy` rises on the request edge. Inputs are driven 2 ns after a rising edge, so a fill count can be checked right after the pushing task returns. Each status check waits at least one further edge, and the timeout check waits enough edges to cover the idle counter plus its status register. Head data is compared by monitors at the falling edge, while the pop is held, and against queues filled by the driver tasks.

// File: rtl/ufs_pkg.sv
// Package: shared entry type for the serial FIFO/status unit.
// Assumes 8-bit characters; the receive entry carries its error flags.
package ufs_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic              ovr;
        logic [CHAR_W-1:0] ch;
    } rx_ent_t;
endpackage

// File: rtl/ufs_fifo.sv
// Module: ufs_fifo
// Synchronous queue with show-ahead head output and a synchronous flush.
// Assumes the caller never writes when full unless it also reads, and never
// reads when empty.
module ufs_fifo #(
    parameter  int W     = 8,
    parameter  int DEPTH = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp, wp_nx, rp_nx;

    // Pointer advance: plain wrap for power-of-two depth, compare otherwise
    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wp_nx = wp + 1'b1;
            assign rp_nx = rp + 1'b1;
        end else begin : g_wrap
            assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        end
    endgenerate

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_en) wp <= wp_nx;
            if (rd_en) rp <= rp_nx;
            if (wr_en && !rd_en)      count <= count + 1'b1;
            else if (rd_en && !wr_en) count <= count - 1'b1;
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (wr_en && !clr) mem[wp] <= wr_data;
    end

    assign head  = mem[rp];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/ufs_rx_path.sv
// Module: ufs_rx_path
// Receive queue plus a one-entry spill slot that keeps the character which
// arrived while the queue was full; that character is tagged as overrun and
// enters the queue as soon as a pop frees a slot.
// Assumes push/pop are already gated by the soft-reset sequencer (clr).
module ufs_rx_path
    import ufs_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  rx_ent_t       push_ent,
    input  logic          pop,
    output rx_ent_t       head,
    output logic [CW-1:0] count
);
    rx_ent_t spill, ovr_ent, f_data;
    logic    spill_v, f_wr, f_full, f_empty, do_pop;

    assign do_pop = pop && !f_empty;

    // Incoming character as it is stored when it caused an overrun
    always_comb begin
        ovr_ent     = push_ent;
        ovr_ent.ovr = 1'b1;
    end

    // Queue write source: the spilled character has priority over new input
    always_comb begin
        f_wr   = 1'b0;
        f_data = push_ent;
        if (spill_v && do_pop) begin
            f_wr   = 1'b1;
            f_data = spill;
        end else if (push && !spill_v && (!f_full || do_pop)) begin
            f_wr   = 1'b1;
        end
    end

    // Spill slot: filled on overrun, drained into the queue on a pop
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            spill_v <= 1'b0;
            spill   <= '0;
        end else if (spill_v && do_pop) begin
            spill_v <= push;
            spill   <= ovr_ent;
        end else if (!spill_v && push && f_full && !do_pop) begin
            spill_v <= 1'b1;
            spill   <= ovr_ent;
        end
    end

    ufs_fifo #(.W($bits(rx_ent_t)), .DEPTH(DEPTH)) rx_q_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (f_wr),
        .wr_data (f_data),
        .rd_en   (do_pop),
        .head    (head),
        .count   (count),
        .full    (f_full),
        .empty   (f_empty)
    );
endmodule

// File: rtl/ufs_stat_irq.sv
// Module: ufs_stat_irq
// Sticky transmit-due, receive-due and receive-timeout status bits, the
// idle-period counter behind the timeout, and the interrupt request.
// Assumes a set condition that still holds wins over a software clear.
module ufs_stat_irq #(
    parameter  int RX_DEPTH = 16,
    parameter  int TX_DEPTH = 8,
    parameter  int TOUT_W   = 8,
    localparam int RX_CW    = $clog2(RX_DEPTH + 1),
    localparam int TX_CW    = $clog2(TX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [RX_CW-1:0]  rx_count,
    input  logic [TX_CW-1:0]  tx_count,
    input  logic              rx_act,
    input  logic              bit_tick,
    input  logic [1:0]        rx_lvl_sel,
    input  logic              tx_lvl_empty,
    input  logic [TOUT_W-1:0] tout_ticks,
    input  logic              st_clr,
    input  logic [2:0]        st_clr_keep,
    input  logic              ie_tx,
    input  logic              ie_rx,
    output logic              tx_due,
    output logic              rx_due,
    output logic              rx_tout,
    output logic              irq
);
    logic [RX_CW-1:0]  rx_lvl;
    logic [TOUT_W-1:0] idle;
    logic              rx_cond, tx_cond, tout_hit, keep_tx, keep_rx, keep_to;

    // Receive threshold decode
    always_comb begin
        case (rx_lvl_sel)
            2'd0:    rx_lvl = RX_CW'(1);
            2'd1:    rx_lvl = RX_CW'(4);
            2'd2:    rx_lvl = RX_CW'(8);
            default: rx_lvl = RX_CW'(12);
        endcase
    end

    assign rx_cond  = (rx_count >= rx_lvl);
    assign tx_cond  = tx_lvl_empty ? (tx_count == '0) : (tx_count != TX_CW'(TX_DEPTH));
    assign tout_hit = (rx_count != '0) && (tout_ticks != '0) && (idle == tout_ticks) && !rx_act;
    assign keep_tx  = !st_clr || st_clr_keep[2];
    assign keep_rx  = !st_clr || st_clr_keep[1];
    assign keep_to  = !st_clr || st_clr_keep[0];

    // Idle bit-period counter, restarted by any receive activity
    always_ff @(posedge clk) begin
        if (!rst_n || clr || rx_act || rx_count == '0) idle <= '0;
        else if (bit_tick && idle != tout_ticks)       idle <= idle + 1'b1;
    end

    // Sticky status bits: set by condition, cleared by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tx_due  <= 1'b0;
            rx_due  <= 1'b0;
            rx_tout <= 1'b0;
        end else begin
            tx_due  <= (tx_due  && keep_tx) || tx_cond;
            rx_due  <= (rx_due  && keep_rx) || rx_cond;
            rx_tout <= (rx_tout && keep_to) || tout_hit;
        end
    end

    assign irq = (tx_due && ie_tx) || ((rx_due || rx_tout) && ie_rx);
endmodule

// File: rtl/uart_fifo_status.sv
// Module: uart_fifo_status (top)
// Receive and transmit queues of a serial port with threshold status,
// timeout, interrupt request, queue flush and soft reset sequencing.
// Assumes single-cycle strobes from the host side and the line engines.
module uart_fifo_status
    import ufs_pkg::*;
#(
    parameter  int RX_DEPTH     = 16,
    parameter  int TX_DEPTH     = 8,
    parameter  int TOUT_W       = 8,
    parameter  int SWRST_CYCLES = 4,
    localparam int RX_CW        = $clog2(RX_DEPTH + 1),
    localparam int TX_CW        = $clog2(TX_DEPTH + 1),
    localparam int SW_W         = $clog2(SWRST_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              rx_push,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [2:0]        rx_err,
    input  logic              rx_pop,
    output logic [CHAR_W-1:0] rx_head_data,
    output logic [3:0]        rx_head_flags,
    output logic [RX_CW-1:0]  rx_fill,
    output logic              rx_none,
    input  logic              tx_wr,
    input  logic [CHAR_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [CHAR_W-1:0] tx_head_data,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              tx_wr_err,
    input  logic [1:0]        rx_lvl_sel,
    input  logic              tx_lvl_empty,
    input  logic [TOUT_W-1:0] tout_ticks,
    input  logic              ie_tx,
    input  logic              ie_rx,
    input  logic              st_clr,
    input  logic [2:0]        st_clr_keep,
    input  logic              fctl_wr,
    input  logic              fctl_rst_en,
    input  logic              fctl_rst_tx,
    input  logic              fctl_rst_rx,
    input  logic              swrst_req,
    output logic              swrst_busy,
    output logic              st_tx_due,
    output logic              st_rx_due,
    output logic              st_rx_tout,
    output logic              irq
);
    logic [SW_W-1:0]  sw_cnt;
    logic             sw_clr, rx_flush, tx_flush, rx_act;
    rx_ent_t          in_ent, hd_ent;
    logic [TX_CW-1:0] tx_count;

    // Soft reset sequencer: busy for a fixed number of cycles
    always_ff @(posedge clk) begin
        if (!rst_n)              sw_cnt <= '0;
        else if (swrst_req)      sw_cnt <= SW_W'(SWRST_CYCLES);
        else if (sw_cnt != '0)   sw_cnt <= sw_cnt - 1'b1;
    end

    assign swrst_busy = (sw_cnt != '0);
    assign sw_clr     = swrst_req || swrst_busy;
    assign rx_flush   = sw_clr || (fctl_wr && fctl_rst_en && fctl_rst_rx);
    assign tx_flush   = sw_clr || (fctl_wr && fctl_rst_en && fctl_rst_tx);
    assign rx_act     = rx_push || rx_pop;

    // Pack the incoming character with its line error bits
    always_comb begin
        in_ent.brk = rx_err[2];
        in_ent.frm = rx_err[1];
        in_ent.par = rx_err[0];
        in_ent.ovr = 1'b0;
        in_ent.ch  = rx_char;
    end

    ufs_rx_path #(.DEPTH(RX_DEPTH)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_flush),
        .push     (rx_push),
        .push_ent (in_ent),
        .pop      (rx_pop),
        .head     (hd_ent),
        .count    (rx_fill)
    );

    // Head status: a break hides framing and parity of the same character
    assign rx_head_data  = hd_ent.ch;
    assign rx_head_flags = {hd_ent.brk, hd_ent.frm && !hd_ent.brk,
                            hd_ent.par && !hd_ent.brk, hd_ent.ovr};
    assign rx_none       = (rx_fill == '0);

    ufs_fifo #(.W(CHAR_W), .DEPTH(TX_DEPTH)) tx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tx_flush),
        .wr_en   (tx_wr && !tx_full),
        .wr_data (tx_wdata),
        .rd_en   (tx_pop && !tx_empty),
        .head    (tx_head_data),
        .count   (tx_count),
        .full    (tx_full),
        .empty   (tx_empty)
    );

    // Sticky write-error flag for writes into a full transmit queue
    always_ff @(posedge clk) begin
        if (!rst_n || sw_clr)      tx_wr_err <= 1'b0;
        else if (tx_wr && tx_full) tx_wr_err <= 1'b1;
    end

    ufs_stat_irq #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .TOUT_W(TOUT_W)) st_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (sw_clr),
        .rx_count     (rx_fill),
        .tx_count     (tx_count),
        .rx_act       (rx_act),
        .bit_tick     (bit_tick),
        .rx_lvl_sel   (rx_lvl_sel),
        .tx_lvl_empty (tx_lvl_empty),
        .tout_ticks   (tout_ticks),
        .st_clr       (st_clr),
        .st_clr_keep  (st_clr_keep),
        .ie_tx        (ie_tx),
        .ie_rx        (ie_rx),
        .tx_due       (st_tx_due),
        .rx_due       (st_rx_due),
        .rx_tout      (st_rx_tout),
        .irq          (irq)
    );
endmodule

// File: rtl/uart_fifo_status_chk.sv
// Module: uart_fifo_status_chk
// Port-level properties of uart_fifo_status, attached by bind.
module uart_fifo_status_chk #(
    parameter int RX_DEPTH = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_push,
    input logic       rx_pop,
    input logic [4:0] rx_fill,
    input logic [3:0] rx_head_flags,
    input logic       rx_none,
    input logic       tx_wr,
    input logic       tx_full,
    input logic       tx_wr_err,
    input logic       ie_tx,
    input logic       ie_rx,
    input logic       fctl_wr,
    input logic       fctl_rst_en,
    input logic       swrst_req,
    input logic       swrst_busy,
    input logic       irq
);
    // R1
    rx_fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fill <= 5'(RX_DEPTH));

    // R1
    rx_push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_pop && rx_fill < 5'(RX_DEPTH) && !swrst_req && !swrst_busy && !fctl_wr)
        |=> rx_fill == $past(rx_fill) + 5'd1);

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_tx && !ie_rx) |-> !irq);

    // R8
    brk_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_head_flags[3] && !rx_none) |-> rx_head_flags[2:1] == 2'b00);

    // R10
    wr_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full && !swrst_req && !swrst_busy) |=> tx_wr_err);

    // R11
    flush_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fctl_wr && !fctl_rst_en && !rx_push && !rx_pop && !swrst_req && !swrst_busy)
        |=> rx_fill == $past(rx_fill));

    // R12
    swrst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_req |=> swrst_busy);
endmodule

bind uart_fifo_status uart_fifo_status_chk #(.RX_DEPTH(RX_DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_push       (rx_push),
    .rx_pop        (rx_pop),
    .rx_fill       (rx_fill),
    .rx_head_flags (rx_head_flags),
    .rx_none       (rx_none),
    .tx_wr         (tx_wr),
    .tx_full       (tx_full),
    .tx_wr_err     (tx_wr_err),
    .ie_tx         (ie_tx),
    .ie_rx         (ie_rx),
    .fctl_wr       (fctl_wr),
    .fctl_rst_en   (fctl_rst_en),
    .swrst_req     (swrst_req),
    .swrst_busy    (swrst_busy),
    .irq           (irq)
);

// File: tb/uart_fifo_status_tb_top.sv
// Scoreboard bench: driver tasks queue expected characters, falling-edge
// monitors compare head data while a pop is held.
module uart_fifo_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, bit_tick, rx_push, rx_pop, tx_wr, tx_pop;
    logic [7:0] rx_char, tx_wdata, tout_ticks;
    logic [2:0] rx_err, st_clr_keep;
    logic [1:0] rx_lvl_sel;
    logic       tx_lvl_empty, ie_tx, ie_rx, st_clr;
    logic       fctl_wr, fctl_rst_en, fctl_rst_tx, fctl_rst_rx, swrst_req;
    logic [7:0] rx_head_data, tx_head_data;
    logic [3:0] rx_head_flags;
    logic [4:0] rx_fill;
    logic       rx_none, tx_full, tx_empty, tx_wr_err, swrst_busy;
    logic       st_tx_due, st_rx_due, st_rx_tout, irq;

    int          n_chk = 0, n_fail = 0, mcnt = 0;
    bit          mspill = 0;
    logic [11:0] mspill_e;
    logic [11:0] rxq[$];
    logic [7:0]  txq[$];

    always #5 clk = ~clk;

    uart_fifo_status dut_i (.*);

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic push_rx(input logic [7:0] c, input logic [2:0] e);
        logic [11:0] ent;
        ent = {e[2], e[1] & ~e[2], e[0] & ~e[2], 1'b0, c};
        rx_char = c; rx_err = e; rx_push = 1'b1;
        cyc();
        rx_push = 1'b0;
        if (mcnt < 16) begin rxq.push_back(ent); mcnt++; end
        else if (!mspill) begin mspill = 1'b1; mspill_e = ent | 12'h100; end
    endtask

    task automatic pop_rx(input int n);
        rx_pop = 1'b1;
        repeat (n) cyc();
        rx_pop = 1'b0;
    endtask

    task automatic wr_tx(input logic [7:0] d);
        tx_wdata = d; tx_wr = 1'b1;
        cyc();
        tx_wr = 1'b0;
        if (txq.size() < 8) txq.push_back(d);
    endtask

    task automatic clr_st(input logic [2:0] keep);
        st_clr_keep = keep; st_clr = 1'b1;
        cyc();
        st_clr = 1'b0;
    endtask

    task automatic fctl(input logic en, input logic t, input logic r);
        fctl_rst_en = en; fctl_rst_tx = t; fctl_rst_rx = r; fctl_wr = 1'b1;
        cyc();
        fctl_wr = 1'b0;
        if (en && r) begin rxq.delete(); mcnt = 0; mspill = 0; end
        if (en && t) txq.delete();
    endtask

    // Receive monitor: compare head against the scoreboard while popping
    always @(negedge clk) begin
        if (rst_n && rx_pop && !rx_none) begin
            if (rxq.size() == 0) chk_eq("R1 unexpected rx data", 1, 0);
            else begin
                chk_eq("R1 R7 R8 rx head", int'({rx_head_flags, rx_head_data}), int'(rxq.pop_front()));
                if (mspill) begin rxq.push_back(mspill_e); mspill = 0; end
                else mcnt--;
            end
        end
    end

    // Transmit monitor: compare head against the scoreboard while popping
    always @(negedge clk) begin
        if (rst_n && tx_pop && !tx_empty) begin
            if (txq.size() == 0) chk_eq("R10 unexpected tx data", 1, 0);
            else chk_eq("R10 tx head", int'(tx_head_data), int'(txq.pop_front()));
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        chk_eq("watchdog expired", 1, 0);
        report();
    end

    initial begin
        rst_n = 0; bit_tick = 0; rx_push = 0; rx_pop = 0; tx_wr = 0; tx_pop = 0;
        rx_char = 0; tx_wdata = 0; rx_err = 0; tout_ticks = 0; rx_lvl_sel = 2'd3;
        tx_lvl_empty = 1; ie_tx = 0; ie_rx = 0; st_clr = 0; st_clr_keep = 3'b111;
        fctl_wr = 0; fctl_rst_en = 0; fctl_rst_tx = 0; fctl_rst_rx = 0; swrst_req = 0;
        repeat (3) cyc();
        chk_eq("R1 reset fill", int'(rx_fill), 0);
        chk_eq("R9 reset none", int'(rx_none), 1);
        chk_eq("R5 reset irq", int'(irq), 0);
        rst_n = 1;
        cyc(); cyc();
        chk_eq("R3 tx due on empty", int'(st_tx_due), 1);

        // R2 threshold 12, varied flags incl. break masking (R8)
        for (int i = 0; i < 11; i++) push_rx(8'(8'h30 + i), 3'(i % 8));
        cyc();
        chk_eq("R2 below level", int'(st_rx_due), 0);
        push_rx(8'h55, 3'b111);
        cyc();
        chk_eq("R2 at level", int'(st_rx_due), 1);
        ie_rx = 1; #1;
        chk_eq("R5 rx irq", int'(irq), 1);
        ie_rx = 0; #1;
        chk_eq("R5 masked", int'(irq), 0);
        ie_tx = 1; #1;
        chk_eq("R5 tx irq", int'(irq), 1);
        ie_tx = 0;
        for (int i = 0; i < 4; i++) push_rx(8'(8'hA0 + i), 3'b010);
        chk_eq("R1 full", int'(rx_fill), 16);

        // R7 overrun: 17th kept with overrun flag, 18th lost
        push_rx(8'hEE, 3'b000);
        push_rx(8'hDD, 3'b000);
        chk_eq("R7 fill stays", int'(rx_fill), 16);
        pop_rx(17);
        chk_eq("R7 drained", int'(rx_fill), 0);
        chk_eq("R9 none after drain", int'(rx_none), 1);

        // R4 clear receive due once its condition is gone
        clr_st(3'b101);
        cyc();
        chk_eq("R4 rx due cleared", int'(st_rx_due), 0);

        // R6 timeout with tick every cycle, 3 periods
        tout_ticks = 8'd3; bit_tick = 1; rx_lvl_sel = 2'd1;
        push_rx(8'h11, 3'b000);
        cyc();
        chk_eq("R6 no early timeout", int'(st_rx_tout), 0);
        repeat (4) cyc();
        chk_eq("R6 timeout set", int'(st_rx_tout), 1);
        pop_rx(1);
        clr_st(3'b110);
        cyc();
        chk_eq("R4 timeout cleared", int'(st_rx_tout), 0);
        bit_tick = 0;

        // R10 transmit queue and write error
        for (int i = 0; i < 8; i++) wr_tx(8'(8'hC0 + i));
        chk_eq("R10 full", int'(tx_full), 1);
        chk_eq("R10 no err yet", int'(tx_wr_err), 0);
        wr_tx(8'hFF);
        chk_eq("R10 wr err", int'(tx_wr_err), 1);
        clr_st(3'b011);
        tx_lvl_empty = 0;
        cyc();
        chk_eq("R3 not due while full", int'(st_tx_due), 0);
        tx_pop = 1; cyc(); tx_pop = 0;
        cyc();
        chk_eq("R3 due when not full", int'(st_tx_due), 1);
        tx_pop = 1; repeat (7) cyc(); tx_pop = 0;
        chk_eq("R10 drained", int'(tx_empty), 1);
        chk_eq("R10 err sticky", int'(tx_wr_err), 1);

        // R11 flush needs enable
        push_rx(8'h21, 3'b000);
        push_rx(8'h22, 3'b000);
        wr_tx(8'h77);
        fctl(1'b0, 1'b1, 1'b1);
        chk_eq("R11 rx kept", int'(rx_fill), 2);
        chk_eq("R11 tx kept", int'(tx_empty), 0);
        fctl(1'b1, 1'b1, 1'b1);
        chk_eq("R11 rx flushed", int'(rx_fill), 0);
        chk_eq("R11 tx flushed", int'(tx_empty), 1);

        // R12 soft reset
        push_rx(8'h31, 3'b000);
        wr_tx(8'h32);
        swrst_req = 1; cyc(); swrst_req = 0;
        rxq.delete(); txq.delete(); mcnt = 0;
        chk_eq("R12 busy", int'(swrst_busy), 1);
        rx_char = 8'h44; rx_push = 1; cyc(); rx_push = 0;
        repeat (5) cyc();
        chk_eq("R12 busy clears", int'(swrst_busy), 0);
        chk_eq("R12 rx empty", int'(rx_fill), 0);
        chk_eq("R12 tx empty", int'(tx_empty), 1);
        chk_eq("R12 err cleared", int'(tx_wr_err), 0);
        report();
    end
endmodule